// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped watchdog timer for a chip's system software. A 32-bit down-counter advances on a counter-clock enable input. Software keeps it from running out by writing two fixed key words, one after the other, to a service register. If the count ever reaches zero while the watchdog is running, a sticky expiry output is raised for the reset controller.

Software programs a reload value in a timeout register. The counter takes that value, raised to a floor of 0x100, when the enable bit goes from 0 to 1 and on every correct key pair. Two control bits let a debug-halt input or a low-power stop input pause the count. The live count can be read only while the watchdog is disabled. Clearing the enable bit pauses the count so that software can read it. Setting the bit again starts a fresh timeout.

The register port is one cycle wide and has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Register byte offsets: control 0x00, timeout 0x08, service 0x10, counter 0x14.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, control reads 0, timeout reads 0xFFFFFFFF, the counter register reads 0xFFFFFFFF and `expired_o` is low.
- R2: Control bit 0 is run enable, bit 1 is freeze-on-debug, bit 2 is stop-on-low-power, and bits 10:9 are the service-mode field. They read back as written. All other control bits read as 0.
- R3: The timeout register reads back its raw value. A counter load uses that value, or 0x100 if the value is below 0x100.
- R4: The counter register (0x14) reads 0 while run enable is 1, and reads the live count while it is 0.
- R5: While run enable is 1, the count drops by exactly one on each cycle where `cnt_tick` is high and no halt applies.
- R6: Writing 0x0000A602 to the service register, and then 0x0000B480 as the next service-register write, loads the counter. Writes to other registers in between do not break the pair. The pair also works while the watchdog is disabled, and it does not enable it.
- R7: Any other service value, a 0xB480 not preceded by 0xA602 as the previous service write, or a pair split by a wrong word does not load the counter. A repeated 0xA602 keeps the pair armed.
- R8: The counter is loaded when run enable goes from 0 to 1. Writing the timeout register alone leaves a running count unchanged.
- R9: With freeze-on-debug set, a high `dbg_halt_i` holds the count. With stop-on-low-power set, a high `lp_stop_i` holds the count. Either input has no effect when its control bit is clear.
- R10: When a running count steps from 1 to 0, `expired_o` goes high and stays high until reset. The count stays at 0. Later loads do not clear `expired_o`.
- R11: Clearing run enable holds the count against further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cnt_tick | input | 1 | Counter-clock enable |
| dbg_halt_i | input | 1 | Debug halt request |
| lp_stop_i | input | 1 | Low-power stop request |
| expired_o | output | 1 | Sticky watchdog expiry |

## Verification
The bench sweeps the load floor across values on both sides of 0x100. A design that clamps at the wrong point, or clamps the stored value instead of the loaded one, fails either the counter read or the timeout read-back. It also sweeps tick counts against a known load and tries each broken key pattern: a lone second key, a wrong word between the keys, a key with high bits set, and keys in reverse order. A tracker that stays armed or compares only 16 bits would reload the counter when it should not. It walks the counter down to zero, checking `expired_o` one tick before and at the step to zero. It then checks that `expired_o` survives later loads and that both halt inputs are ignored when their control bits are clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned OFS_W = 5;

    localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [OFS_W-1:0] OFS_TOUT = 5'h08;
    localparam logic [OFS_W-1:0] OFS_SVC  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_CNT  = 5'h14;

    localparam int unsigned CB_RUN     = 0;
    localparam int unsigned CB_FRZ     = 1;
    localparam int unsigned CB_STP     = 2;
    localparam int unsigned CB_MODE_LO = 9;
    localparam int unsigned CB_MODE_HI = 10;

    typedef struct packed {
        logic [1:0] mode;
        logic       stop_en;
        logic       frz_en;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic tout;
        logic svc;
    } wr_sel_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.mode    = w[CB_MODE_HI:CB_MODE_LO];
        c.stop_en = w[CB_STP];
        c.frz_en  = w[CB_FRZ];
        c.run     = w[CB_RUN];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CB_MODE_HI:CB_MODE_LO] = c.mode;
        w[CB_STP] = c.stop_en;
        w[CB_FRZ] = c.frz_en;
        w[CB_RUN] = c.run;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] floor_load(input logic [REG_W-1:0] v,
                                                    input logic [REG_W-1:0] minv);
        return (v < minv) ? minv : v;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter logic [REG_W-1:0] TOUT_RESET = '1,
    parameter logic [REG_W-1:0] MIN_LOAD   = 32'h100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] tout_raw,
    output logic [REG_W-1:0] load_value,
    output wr_sel_t          sel,
    output logic             run_rise
);

    ctrl_t            ctrl_q;
    logic [REG_W-1:0] tout_q;
    ctrl_t            ctrl_new;

    always_comb begin
        sel.ctrl = bus_wr && (bus_addr == OFS_CTRL);
        sel.tout = bus_wr && (bus_addr == OFS_TOUT);
        sel.svc  = bus_wr && (bus_addr == OFS_SVC);
        ctrl_new = ctrl_unpack(bus_wdata);
        run_rise = sel.ctrl && ctrl_new.run && !ctrl_q.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tout_q <= TOUT_RESET;
        end else begin
            if (sel.ctrl) ctrl_q <= ctrl_new;
            if (sel.tout) tout_q <= bus_wdata;
        end
    end

    assign ctrl       = ctrl_q;
    assign tout_raw   = tout_q;
    assign load_value = floor_load(tout_q, MIN_LOAD);

    // R8: a timeout write never changes the run bit
    a_r8_tout_keeps_run: assert property (@(posedge clk) disable iff (rst)
        (sel.tout && !sel.ctrl) |=> $stable(ctrl_q.run));

endmodule

// File: rtl/wdg_key_tracker.sv
module wdg_key_tracker
    import wdg_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY_A = 32'h0000A602,
    parameter logic [REG_W-1:0] KEY_B = 32'h0000B480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             svc_wr,
    input  logic [REG_W-1:0] svc_data,
    output logic             reload,
    output key_state_e       state
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        reload  = 1'b0;
        if (svc_wr) begin
            if (svc_data == KEY_A) begin
                state_d = KEY_ARMED;
            end else if (state_q == KEY_ARMED && svc_data == KEY_B) begin
                reload  = 1'b1;
                state_d = KEY_IDLE;
            end else begin
                state_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R7: a completed pair leaves the tracker idle
    a_r7_reload_disarms: assert property (@(posedge clk) disable iff (rst)
        reload |=> (state_q == KEY_IDLE));

    // R7: a non-service cycle keeps the tracker state
    a_r7_idle_bus_holds: assert property (@(posedge clk) disable iff (rst)
        !svc_wr |=> $stable(state_q));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter logic [REG_W-1:0] CNT_RESET = '1,
    parameter logic [REG_W-1:0] MIN_LOAD  = 32'h100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_value,
    input  logic             run,
    input  logic             tick,
    input  logic             halt,
    output logic [REG_W-1:0] cnt,
    output logic             expired
);

    logic [REG_W-1:0] cnt_q;
    logic             exp_q;
    logic             step;

    assign step = run && tick && !halt && !load && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_RESET;
            exp_q <= 1'b0;
        end else begin
            if (load)      cnt_q <= load_value;
            else if (step) cnt_q <= cnt_q - REG_W'(1);
            if (step && cnt_q == REG_W'(1)) exp_q <= 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign expired = exp_q;

    // R5: without a load the count moves by at most one per cycle, downward
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - REG_W'(1)));

    // R3: a load never sets a count below the floor
    a_r3_load_floor: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q >= MIN_LOAD));

    // R9, R11: halted or stopped counter holds its value
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
        ((halt || !run) && !load) |=> $stable(cnt_q));

    // R10: expiry is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        exp_q |=> exp_q);

    // R10: expiry appears together with a zero count
    a_r10_zero_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(exp_q) |-> (cnt_q == '0));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter logic [REG_W-1:0] TOUT_RESET = 32'hFFFF_FFFF,
    parameter logic [REG_W-1:0] MIN_LOAD   = 32'h0000_0100,
    parameter logic [REG_W-1:0] KEY_A      = 32'h0000_A602,
    parameter logic [REG_W-1:0] KEY_B      = 32'h0000_B480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             cnt_tick,
    input  logic             dbg_halt_i,
    input  logic             lp_stop_i,
    output logic             expired_o
);

    localparam logic [REG_W-1:0] CNT_RESET = (TOUT_RESET < MIN_LOAD) ? MIN_LOAD : TOUT_RESET;

    ctrl_t            ctrl;
    logic [REG_W-1:0] tout_raw;
    logic [REG_W-1:0] load_value;
    wr_sel_t          sel;
    logic             run_rise;
    logic             key_reload;
    key_state_e       key_state;
    logic             halt;
    logic             load;
    logic [REG_W-1:0] cnt;

    wdg_regs #(
        .TOUT_RESET (TOUT_RESET),
        .MIN_LOAD   (MIN_LOAD)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ctrl       (ctrl),
        .tout_raw   (tout_raw),
        .load_value (load_value),
        .sel        (sel),
        .run_rise   (run_rise)
    );

    wdg_key_tracker #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_keys (
        .clk      (clk),
        .rst      (rst),
        .svc_wr   (sel.svc),
        .svc_data (bus_wdata),
        .reload   (key_reload),
        .state    (key_state)
    );

    assign halt = (ctrl.frz_en && dbg_halt_i) || (ctrl.stop_en && lp_stop_i);
    assign load = run_rise || key_reload;

    wdg_counter #(
        .CNT_RESET (CNT_RESET),
        .MIN_LOAD  (MIN_LOAD)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_value (load_value),
        .run        (ctrl.run),
        .tick       (cnt_tick),
        .halt       (halt),
        .cnt        (cnt),
        .expired    (expired_o)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_pack(ctrl);
            OFS_TOUT: bus_rdata = tout_raw;
            OFS_CNT:  bus_rdata = ctrl.run ? '0 : cnt;
            default:  bus_rdata = '0;
        endcase
    end

    // R6: a key reload never changes the run bit by itself
    a_r6_keys_leave_run: assert property (@(posedge clk) disable iff (rst)
        (key_reload && !sel.ctrl) |=> $stable(ctrl.run));

    // R7: second key while idle gives no load
    a_r7_no_lone_key: assert property (@(posedge clk) disable iff (rst)
        (sel.svc && key_state == KEY_IDLE && !sel.ctrl) |-> !load);

endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
    import wdg_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             bus_wr;
    logic [OFS_W-1:0] bus_addr;
    logic [REG_W-1:0] bus_wdata;
    logic [REG_W-1:0] bus_rdata;
    logic             cnt_tick;
    logic             dbg_halt_i;
    logic             lp_stop_i;
    logic             expired_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] KA = 32'h0000A602;
    localparam logic [31:0] KB = 32'h0000B480;

    always #10 clk = ~clk;

    keyed_watchdog i_keyed_watchdog (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_tick   (cnt_tick),
        .dbg_halt_i (dbg_halt_i),
        .lp_stop_i  (lp_stop_i),
        .expired_o  (expired_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [OFS_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [OFS_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            cnt_tick = 1'b1;
            repeat (n) @(negedge clk);
            cnt_tick = 1'b0;
        end
    endtask

    task automatic keys;
        wr(OFS_SVC, KA);
        wr(OFS_SVC, KB);
    endtask

    function automatic logic [31:0] floorv(input logic [31:0] v);
        return (v < 32'h100) ? 32'h100 : v;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] vals [8];
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        cnt_tick = 1'b0; dbg_halt_i = 1'b0; lp_stop_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFS_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(OFS_TOUT, v); chk("R1 timeout", v, 32'hFFFF_FFFF);
        rd(OFS_CNT, v);  chk("R1 counter", v, 32'hFFFF_FFFF);
        chk("R1 expired", {31'b0, expired_o}, 32'h0);

        // R2 control fields, R4 counter hidden while running
        wr(OFS_CTRL, 32'hFFFF_FFFF);
        rd(OFS_CTRL, v); chk("R2 ctrl readback", v, 32'h0000_0607);
        rd(OFS_CNT, v);  chk("R4 counter zero while running", v, 32'h0);
        wr(OFS_CTRL, 32'h0000_0600);
        rd(OFS_CTRL, v); chk("R2 mode only", v, 32'h0000_0600);
        wr(OFS_CTRL, 32'h0);

        // R3 floor sweep via enable load
        vals = '{32'h0, 32'h1, 32'h80, 32'hFF, 32'h100, 32'h101, 32'h2000, 32'hFFFF_FFFF};
        foreach (vals[i]) begin
            wr(OFS_TOUT, vals[i]);
            rd(OFS_TOUT, v); chk("R3 raw timeout", v, vals[i]);
            wr(OFS_CTRL, 32'h1);
            wr(OFS_CTRL, 32'h0);
            rd(OFS_CNT, v); chk("R3 floored load", v, floorv(vals[i]));
        end

        // R5 decrement sweep, R4 live count when stopped
        wr(OFS_TOUT, 32'h200);
        for (int n = 0; n <= 40; n++) begin
            wr(OFS_CTRL, 32'h1);
            ticks(n);
            wr(OFS_CTRL, 32'h0);
            rd(OFS_CNT, v); chk("R5 ticks", v, 32'h200 - n);
        end

        // R11 hold while disabled; R8 re-enable reloads
        wr(OFS_CTRL, 32'h1); ticks(9); wr(OFS_CTRL, 32'h0);
        ticks(10);
        rd(OFS_CNT, v); chk("R11 held count", v, 32'h200 - 9);
        wr(OFS_CTRL, 32'h1); wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R8 re-enable reload", v, 32'h200);

        // R8 timeout write leaves running count
        wr(OFS_CTRL, 32'h1); ticks(3);
        wr(OFS_TOUT, 32'h900);
        ticks(2);
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R8 running count kept", v, 32'h200 - 5);

        // R9 freeze and stop
        wr(OFS_TOUT, 32'h200);
        wr(OFS_CTRL, 32'h3);
        dbg_halt_i = 1'b1; ticks(30); dbg_halt_i = 1'b0; ticks(5);
        wr(OFS_CTRL, 32'h2);
        rd(OFS_CNT, v); chk("R9 freeze holds", v, 32'h200 - 5);
        wr(OFS_CTRL, 32'h1);
        dbg_halt_i = 1'b1; ticks(7); dbg_halt_i = 1'b0;
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R9 debug ignored when bit clear", v, 32'h200 - 7);
        wr(OFS_CTRL, 32'h5);
        lp_stop_i = 1'b1; ticks(20); lp_stop_i = 1'b0; ticks(4);
        wr(OFS_CTRL, 32'h4);
        rd(OFS_CNT, v); chk("R9 stop holds", v, 32'h200 - 4);
        wr(OFS_CTRL, 32'h3);
        lp_stop_i = 1'b1; ticks(6); lp_stop_i = 1'b0;
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R9 stop ignored when bit clear", v, 32'h200 - 6);

        // R6 service while disabled
        wr(OFS_TOUT, 32'h345);
        keys();
        rd(OFS_CNT, v);  chk("R6 disabled service load", v, 32'h345);
        rd(OFS_CTRL, v); chk("R6 service leaves run clear", v, 32'h0);
        // R6 service while running
        wr(OFS_TOUT, 32'h300);
        wr(OFS_CTRL, 32'h1); ticks(50);
        keys();
        ticks(4);
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R6 running service reload", v, 32'h300 - 4);
        // R6 other register write between keys
        wr(OFS_SVC, KA);
        wr(OFS_TOUT, 32'h333);
        wr(OFS_SVC, KB);
        rd(OFS_CNT, v); chk("R6 pair across other write", v, 32'h333);

        // R7 broken sequences
        wr(OFS_TOUT, 32'h150); keys();
        wr(OFS_TOUT, 32'h400);
        wr(OFS_SVC, KB);
        rd(OFS_CNT, v); chk("R7 lone second key", v, 32'h150);
        wr(OFS_SVC, KA); wr(OFS_SVC, 32'h1234); wr(OFS_SVC, KB);
        rd(OFS_CNT, v); chk("R7 wrong word between", v, 32'h150);
        wr(OFS_SVC, 32'h0001_A602); wr(OFS_SVC, KB);
        rd(OFS_CNT, v); chk("R7 high bits on first key", v, 32'h150);
        wr(OFS_SVC, KB); wr(OFS_SVC, KA);
        rd(OFS_CNT, v); chk("R7 reversed order", v, 32'h150);
        wr(OFS_SVC, 32'h0);
        wr(OFS_SVC, KA); wr(OFS_SVC, KA); wr(OFS_SVC, KB);
        rd(OFS_CNT, v); chk("R7 repeated first key rearms", v, 32'h400);

        // R10 expiry
        wr(OFS_TOUT, 32'h100);
        wr(OFS_CTRL, 32'h1);
        ticks(32'hFF);
        #1 chk("R10 not yet expired", {31'b0, expired_o}, 32'h0);
        ticks(1);
        #1 chk("R10 expired at zero", {31'b0, expired_o}, 32'h1);
        ticks(5);
        wr(OFS_CTRL, 32'h0);
        rd(OFS_CNT, v); chk("R10 count stays zero", v, 32'h0);
        keys();
        rd(OFS_CNT, v); chk("R10 reload after expiry", v, 32'h100);
        chk("R10 expiry sticky after load", {31'b0, expired_o}, 32'h1);
        wr(OFS_CTRL, 32'h1); ticks(3);
        #1 chk("R10 expiry sticky while running", {31'b0, expired_o}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule